// File: doc/BRIEF.md
# Allocation Stall Clock-Gate Predictor

This block sits next to the allocation stage of an out-of-order pipeline. Whenever the reorder buffer reports that it is full, the allocator must stall. A plain allocator would re-test that condition on every cycle and keep its logic clocked while it waits. This block instead forecasts whether the buffer will still be full on the next cycle. When the forecast says the full condition will persist, the block holds the stall and drops the allocator's clock enable for that cycle.

The forecast uses two inputs from the reorder buffer: the full flag and a count of entries it expects to retire on the next cycle. The block turns gating on only after the buffer has stayed full for a configurable number of consecutive cycles, and only while no retirement is announced. The reorder buffer announces a retirement one cycle before the buffer stops being full. That notice alone re-opens the clock, so the allocator is already clocked in the cycle in which space appears.

The clock-gating cell itself is outside this block; here it is represented only by its enable. A saturating count of gated cycles is exposed so that the amount of gating can be measured.

Top module: `alloc_gate_predictor`

## Requirements
- R1: In the first cycle after reset is released, `alloc_clk_en` is 1 and `gated_cycles` is 0.
- R2: `alloc_stall` equals `rob_full` in the same cycle, with no register in between.
- R3: If, in some cycle, `rob_full` has been 1 for at least `GATE_AFTER` consecutive cycles (counting that cycle) and `retire_hint` is 0, then `alloc_clk_en` is 0 in the next cycle.
- R4: If `retire_hint` is nonzero in a cycle, `alloc_clk_en` is 1 in the next cycle. Any nonzero value has the same effect.
- R5: If `rob_full` is 0 in a cycle, `alloc_clk_en` is 1 in the next cycle.
- R6: If `rob_full` has been 1 for fewer than `GATE_AFTER` consecutive cycles, `alloc_clk_en` is 1 in the next cycle.
- R7: `gated_cycles` goes up by one after each cycle in which `alloc_clk_en` is 0. It stays unchanged otherwise, and it saturates at all ones.
- R8: This requirement assumes the reorder buffer gives a nonzero `retire_hint` in the cycle before `rob_full` falls. Under that assumption, `alloc_clk_en` is 1 in every cycle in which `rob_full` has just fallen, so resuming allocation costs no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rob_full | input | 1 | Reorder buffer is full this cycle |
| retire_hint | input | RET_W | Entries the reorder buffer expects to retire next cycle |
| alloc_stall | output | 1 | Allocator must stall this cycle |
| alloc_clk_en | output | 1 | Enable for the allocator's clock-gating cell |
| gated_cycles | output | CNT_W | Saturating count of cycles with the clock enable low |

## Verification
The bench builds the block with `GATE_AFTER` = 3, `RET_W` = 2 and `CNT_W` = 4. With these values, a full streak that is one cycle short of the threshold can be told apart from one that reaches it. A gated stretch of about twenty cycles drives the 4-bit counter into saturation. A hint value of 2 shows that any nonzero count re-opens the clock. A reset applied mid-run, after saturation, shows that the counter and the enable return to their initial values.

// File: rtl/alloc_gate_pkg.sv
// Shared definitions for the allocation clock-gate predictor.
// Assumes: nothing beyond a standard SystemVerilog elaborator.
package alloc_gate_pkg;

    // Level of the allocator clock enable
    typedef enum logic {
        CLK_HELD = 1'b0,
        CLK_RUN  = 1'b1
    } clk_state_e;

endpackage

// File: rtl/alloc_full_run.sv
// Tracks how long the reorder buffer has stayed full and raises
// streak_met once the current cycle completes a run of GATE_AFTER
// consecutive full cycles.
// Assumes: rob_full is sampled once per cycle; reset is synchronous and active low.
module alloc_full_run #(
    parameter int GATE_AFTER = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rob_full,
    output logic streak_met
);
    localparam int RUN_W = (GATE_AFTER > 1) ? $clog2(GATE_AFTER) : 1;

    generate
        if (GATE_AFTER <= 1) begin : g_direct
            // A single full cycle is enough; no history is kept
            assign streak_met = rob_full;
        end else begin : g_count
            localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(GATE_AFTER - 1);
            logic [RUN_W-1:0] run_q;

            // Count earlier consecutive full cycles, saturating at GATE_AFTER-1
            always_ff @(posedge clk) begin
                if (!rst_n)              run_q <= '0;
                else if (!rob_full)      run_q <= '0;
                else if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
            end

            assign streak_met = rob_full && (run_q == RUN_TOP);

            // R6
            short_streak_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !rob_full |=> !streak_met || (GATE_AFTER <= 1));
        end
    endgenerate

endmodule

// File: rtl/alloc_gate_decide.sv
// Registers the prediction for the next cycle. The clock is held when the
// full streak is established and no retirement is announced. Any announced
// retirement re-opens the clock one cycle ahead.
// Assumes: retire_hint is valid in every cycle.
module alloc_gate_decide
    import alloc_gate_pkg::*;
#(
    parameter int RET_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rob_full,
    input  logic             streak_met,
    input  logic [RET_W-1:0] retire_hint,
    output logic             clk_en
);
    clk_state_e state_q;
    logic       hold_next;

    // Predict that the buffer stays full through the next cycle
    always_comb hold_next = streak_met && (retire_hint == '0);

    // Latch the prediction as next cycle's enable; run the clock out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CLK_RUN;
        else        state_q <= hold_next ? CLK_HELD : CLK_RUN;
    end

    assign clk_en = (state_q == CLK_RUN);

    // R4
    hint_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_hint != '0) |=> clk_en);

    // R5
    empty_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rob_full |=> clk_en);

endmodule

// File: rtl/alloc_gated_count.sv
// Saturating counter of cycles in which the allocator clock was held.
// Assumes: clk_en is the registered enable of the same cycle.
module alloc_gated_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Add one for each held cycle, stopping at all ones
    always_ff @(posedge clk) begin
        if (!rst_n)                         count <= '0;
        else if (!clk_en && count != CNT_MAX) count <= count + 1'b1;
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX) |=> (count == CNT_MAX));

    // R7
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && count != CNT_MAX) |=> (count == $past(count) + 1'b1));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |=> $stable(count));

endmodule

// File: rtl/alloc_gate_predictor.sv
// Top of the allocation stall clock-gate predictor. Stall follows the
// full flag directly; the clock enable is a one-cycle-ahead forecast of
// whether the full condition persists.
// Assumes: the reorder buffer raises retire_hint the cycle before rob_full falls.
module alloc_gate_predictor #(
    parameter int GATE_AFTER = 3,
    parameter int RET_W      = 2,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rob_full,
    input  logic [RET_W-1:0] retire_hint,
    output logic             alloc_stall,
    output logic             alloc_clk_en,
    output logic [CNT_W-1:0] gated_cycles
);
    logic streak_met;

    // Stall is never predicted: it tracks the buffer every cycle
    assign alloc_stall = rob_full;

    alloc_full_run #(.GATE_AFTER(GATE_AFTER)) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .rob_full   (rob_full),
        .streak_met (streak_met)
    );

    alloc_gate_decide #(.RET_W(RET_W)) u_decide (
        .clk         (clk),
        .rst_n       (rst_n),
        .rob_full    (rob_full),
        .streak_met  (streak_met),
        .retire_hint (retire_hint),
        .clk_en      (alloc_clk_en)
    );

    alloc_gated_count #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (alloc_clk_en),
        .count  (gated_cycles)
    );

    // R8
    no_lost_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rob_full) && $past(retire_hint) != '0) |-> alloc_clk_en);

    // R3
    held_means_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_clk_en |-> $past(rob_full));

endmodule

// File: tb/alloc_gate_predictor_bench.sv
// Scoreboard bench: the driver applies one cycle of stimulus and queues the
// expected post-edge outputs; the monitor pops and compares after each edge.
module alloc_gate_predictor_bench;
    localparam int G  = 3;
    localparam int RW = 2;
    localparam int CW = 4;

    typedef struct {
        logic          en;
        logic [CW-1:0] cnt;
        int            req;
    } exp_t;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          rob_full = 0;
    logic [RW-1:0] retire_hint = '0;
    logic          alloc_stall, alloc_clk_en;
    logic [CW-1:0] gated_cycles;

    int   n_checks = 0;
    int   n_fail   = 0;
    exp_t sb[$];

    // model state
    logic          m_en  = 1'b1;
    logic [CW-1:0] m_cnt = '0;
    int            m_run = 0;

    always #4 clk = ~clk;   // 125 MHz

    alloc_gate_predictor #(.GATE_AFTER(G), .RET_W(RW), .CNT_W(CW)) u_alloc_gate_predictor (
        .clk          (clk),
        .rst_n        (rst_n),
        .rob_full     (rob_full),
        .retire_hint  (retire_hint),
        .alloc_stall  (alloc_stall),
        .alloc_clk_en (alloc_clk_en),
        .gated_cycles (gated_cycles)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, expected result queued for the monitor
    task automatic step(input logic f, input logic [RW-1:0] h, input int req);
        exp_t e;
        int   c;
        @(negedge clk);
        rob_full    = f;
        retire_hint = h;
        #1;
        check("R2 stall", alloc_stall, f);
        e.cnt = (!m_en && m_cnt != '1) ? m_cnt + 1'b1 : m_cnt;
        c     = f ? ((m_run + 1 > G) ? G : m_run + 1) : 0;
        e.en  = !(f && h == '0 && c >= G);
        e.req = req;
        m_run = c;
        m_en  = e.en;
        m_cnt = e.cnt;
        sb.push_back(e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; rob_full = 0; retire_hint = '0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_en = 1'b1; m_cnt = '0; m_run = 0;
        #1;
        check("R1 clk_en", alloc_clk_en, 1);
        check("R1 count", gated_cycles, 0);
    endtask

    // Monitor: compare after each active edge
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check($sformatf("R%0d clk_en", e.req), alloc_clk_en, e.en);
            check("R7 count", gated_cycles, e.cnt);
            if (!rob_full && e.req == 8) check("R8 no lost cycle", alloc_clk_en, 1);
        end
    end

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R5: empty buffer keeps clock running
        step(0, 0, 5); step(0, 0, 5);
        // R6: short full streaks never gate
        step(1, 0, 6); step(1, 0, 6); step(1, 1, 4); step(0, 0, 8);
        // R4: full for long but retirement always announced
        for (int i = 0; i < 6; i++) step(1, 2'd3, 4);
        step(0, 0, 8);
        // R3 + R7: long full stretch, gate and saturate counter
        for (int i = 0; i < 22; i++) step(1, 0, 3);
        // R4: hint of 2 wakes clock, then R8 buffer drains
        step(1, 2'd2, 4);
        step(0, 0, 8);
        step(0, 0, 5);
        // R3: gate again, short hold, then wake
        for (int i = 0; i < 5; i++) step(1, 0, 3);
        step(1, 2'd1, 4);
        step(0, 0, 8);
        @(negedge clk); @(negedge clk);
        // R1: mid-run reset after saturation
        do_reset();
        step(1, 0, 6); step(1, 0, 6); step(1, 0, 3); step(1, 0, 3);
        step(1, 2'd1, 4); step(0, 0, 8);
        @(negedge clk); @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule